// File: doc/BRIEF.md
# Dual-Pointer Video Memory Access Port

This block gives an 8-bit host a register window into a 17-bit byte-addressed video memory. It keeps two independent address pointers. Each pointer has three address bytes and a data window. Reading or writing a data window steps that pointer by its programmed stride and starts a new prefetch. The value a window returns is the byte last fetched for its own pointer. A fetch is started only when that pointer moves, so a window can go stale after another path writes memory.

A control byte picks which pointer the three main address registers act on. The same byte holds an auxiliary-window select field. When that field carries the dual code, four auxiliary offsets map the three address bytes of the pointer that is not selected. With this, the host can reach both pointers without switching the port select. Memory traffic leaves through one request channel with a valid/ready handshake and a read-response strobe. Requests are served one at a time, with pointer 0 first.

Top module: `vport_top`

## Requirements
- R1: After reset both pointers, both strides, both data latches and the control byte are zero, and every register offset reads zero.
- R2: Offsets 0x00, 0x01 and 0x02 read and write address bits 7:0, bits 15:8 and the high byte of the pointer chosen by control bit 0 (0 selects pointer 0, 1 selects pointer 1).
- R3: The high byte carries address bit 16 in bit 0, a decrement flag in bit 3 and a stride code in bits 7:4. Bits 2:1 read as zero. Code 0 means a step of 0, and code k (k≥1) means a step of 2^(k-1).
- R4: Offsets 0x03 and 0x04 are the data windows of pointers 0 and 1. A read returns the latched byte. Any access, read or write, moves that pointer by its step (subtracting when the decrement flag is set), modulo 2^17, and then prefetches the new address.
- R5: A write to any address byte of a pointer starts a prefetch of that pointer's new address. The latch takes the memory response.
- R6: A write to a data window stores the byte at the address the pointer held before it moved.
- R7: A write through one window never refreshes the other window's latch, even when both pointers hold the same address.
- R8: Offset 0x05 is the control byte. Bit 0 is the port select and bits 6:1 are the auxiliary select. Bit 7 always reads zero.
- R9: With auxiliary select 6, offsets 0x09, 0x0A and 0x0B read and write bits 7:0, bits 15:8 and the high byte of the pointer that is not selected. Offset 0x0C reads zero and ignores writes.
- R10: With any other auxiliary select, offsets 0x09 to 0x0C read zero and ignore writes.
- R11: At most one memory read is outstanding. When both pointers wait for memory at once, pointer 0 is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Host access strobe, one cycle per access |
| cpu_we | input | 1 | Host write when high, read when low |
| cpu_ofs | input | 4 | Register offset |
| cpu_wdata | input | 8 | Host write data |
| cpu_rdata | output | 8 | Host read data, combinational from the offset |
| mem_req | output | 1 | Memory request valid |
| mem_gnt | input | 1 | Memory request ready |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 17 | Request address |
| mem_wdata | output | 8 | Request write data |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 8 | Read response data |

## Verification
Two things can fall in the same cycle: prefetch demands from both pointers, and a pointer move that lands while that pointer's earlier fetch is still in flight. The bench provokes the first case by holding the memory ready signal low. While it is low, the bench touches pointer 0 through the main registers and pointer 1 through the auxiliary window on back-to-back cycles, so both demands wait together. On release it records the first granted address, which must be pointer 0's, and then checks that both latches end up with the right bytes. The stale-window case uses two pointers at one address: a byte is written through window 1, and window 0 must still show the old byte until its own pointer is accessed.

// File: rtl/vport_pkg.sv
package vport_pkg;
  localparam int VA_W   = 17;
  localparam int BYTE_W = 8;
  localparam int NPORT  = 2;
  localparam int SEL_W  = $clog2(NPORT);

  function automatic logic [VA_W-1:0] stride_of(input logic [3:0] code);
    if (code == 4'd0) return '0;
    return VA_W'(1) << (code - 4'd1);
  endfunction

  function automatic logic [VA_W-1:0] step_addr(input logic [VA_W-1:0] a,
                                                input logic [3:0] code,
                                                input logic dec);
    return dec ? a - stride_of(code) : a + stride_of(code);
  endfunction

  function automatic logic [BYTE_W-1:0] hi_view(input logic [VA_W-1:0] a,
                                                input logic [3:0] code,
                                                input logic dec);
    return {code, dec, 2'b00, a[VA_W-1]};
  endfunction
endpackage

// File: rtl/vport_ptr.sv
module vport_ptr
  import vport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_lo,
  input  logic              we_mid,
  input  logic              we_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              win_rd,
  input  logic              win_wr,
  input  logic              grant_wr,
  input  logic              grant_rd,
  input  logic              rsp_vld,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic [VA_W-1:0]   ptr,
  output logic [3:0]        code,
  output logic              dec,
  output logic [BYTE_W-1:0] lat,
  output logic              wr_pend,
  output logic [VA_W-1:0]   wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_pend,
  output logic              touch
);
  logic win_acc;
  assign win_acc = win_rd | win_wr;
  assign touch   = we_lo | we_mid | we_hi | win_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      code    <= '0;
      dec     <= 1'b0;
      lat     <= '0;
      wr_pend <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_pend <= 1'b0;
    end else begin
      if (we_lo)  ptr[7:0]  <= wdata;
      if (we_mid) ptr[15:8] <= wdata;
      if (we_hi) begin
        ptr[VA_W-1] <= wdata[0];
        dec         <= wdata[3];
        code        <= wdata[7:4];
      end
      if (win_acc) ptr <= step_addr(ptr, code, dec);
      if (win_wr) begin
        wr_pend <= 1'b1;
        wr_addr <= ptr;
        wr_data <= wdata;
      end else if (grant_wr) begin
        wr_pend <= 1'b0;
      end
      if (touch)         rd_pend <= 1'b1;
      else if (grant_rd) rd_pend <= 1'b0;
      if (rsp_vld) lat <= rsp_data;
    end
  end
endmodule

// File: rtl/vport_arb.sv
module vport_arb
  import vport_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             wr_pend,
  input  logic [NPORT-1:0]             rd_pend,
  input  logic [NPORT-1:0][VA_W-1:0]   wr_addr,
  input  logic [NPORT-1:0][BYTE_W-1:0] wr_data,
  input  logic [NPORT-1:0][VA_W-1:0]   rd_addr,
  input  logic                         mem_gnt,
  input  logic                         mem_rvalid,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [VA_W-1:0]              mem_addr,
  output logic [BYTE_W-1:0]            mem_wdata,
  output logic [NPORT-1:0]             grant_wr,
  output logic [NPORT-1:0]             grant_rd,
  output logic [NPORT-1:0]             rsp_vld
);
  logic             busy;
  logic [SEL_W-1:0] owner;
  logic [SEL_W-1:0] sel;
  logic             sel_we;
  logic             hs;

  // lowest index wins; within a port the write goes before the fetch
  always_comb begin
    sel    = '0;
    sel_we = 1'b0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (rd_pend[p]) begin sel = SEL_W'(p); sel_we = 1'b0; end
      if (wr_pend[p]) begin sel = SEL_W'(p); sel_we = 1'b1; end
    end
  end

  assign mem_req   = (|wr_pend | |rd_pend) & ~busy;
  assign mem_we    = sel_we;
  assign mem_addr  = sel_we ? wr_addr[sel] : rd_addr[sel];
  assign mem_wdata = wr_data[sel];
  assign hs        = mem_req & mem_gnt;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      grant_wr[p] = hs &  sel_we & (sel == SEL_W'(p));
      grant_rd[p] = hs & ~sel_we & (sel == SEL_W'(p));
      rsp_vld[p]  = mem_rvalid & busy & (owner == SEL_W'(p));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
    end else if (hs && !sel_we) begin
      busy  <= 1'b1;
      owner <= sel;
    end else if (mem_rvalid) begin
      busy  <= 1'b0;
    end
  end
endmodule

// File: rtl/vport_top.sv
module vport_top
  import vport_pkg::*;
#(
  parameter int DUAL_CODE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [3:0]        cpu_ofs,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic [VA_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic [6:0] ctrl_q;
  logic       port_sel;
  logic       dual;
  logic       host_wr;
  logic       host_rd;
  logic       alt_sel;

  logic [NPORT-1:0][VA_W-1:0]   ptr_q;
  logic [NPORT-1:0][3:0]        code_q;
  logic [NPORT-1:0]             dec_q;
  logic [NPORT-1:0][BYTE_W-1:0] lat_q;
  logic [NPORT-1:0]             wr_pend;
  logic [NPORT-1:0][VA_W-1:0]   wr_addr;
  logic [NPORT-1:0][BYTE_W-1:0] wr_data;
  logic [NPORT-1:0]             rd_pend;
  // named events for the checker
  logic [NPORT-1:0]             p_touch;
  logic [NPORT-1:0]             write_grant;
  logic [NPORT-1:0]             fetch_grant;
  logic [NPORT-1:0]             rsp_route;

  assign port_sel = ctrl_q[0];
  assign alt_sel  = ~ctrl_q[0];
  assign dual     = (ctrl_q[6:1] == 6'(DUAL_CODE));
  assign host_wr  = cpu_sel &  cpu_we;
  assign host_rd  = cpu_sel & ~cpu_we;

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctrl_q <= '0;
    else if (host_wr && cpu_ofs == 4'h5) ctrl_q <= cpu_wdata[6:0];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_ptr
    logic main_hit, aux_hit;
    assign main_hit = (port_sel == SEL_W'(p));
    assign aux_hit  = dual && (port_sel != SEL_W'(p));

    vport_ptr u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_lo    (host_wr && ((main_hit && cpu_ofs == 4'h0) || (aux_hit && cpu_ofs == 4'h9))),
      .we_mid   (host_wr && ((main_hit && cpu_ofs == 4'h1) || (aux_hit && cpu_ofs == 4'hA))),
      .we_hi    (host_wr && ((main_hit && cpu_ofs == 4'h2) || (aux_hit && cpu_ofs == 4'hB))),
      .wdata    (cpu_wdata),
      .win_rd   (host_rd && cpu_ofs == 4'(3 + p)),
      .win_wr   (host_wr && cpu_ofs == 4'(3 + p)),
      .grant_wr (write_grant[p]),
      .grant_rd (fetch_grant[p]),
      .rsp_vld  (rsp_route[p]),
      .rsp_data (mem_rdata),
      .ptr      (ptr_q[p]),
      .code     (code_q[p]),
      .dec      (dec_q[p]),
      .lat      (lat_q[p]),
      .wr_pend  (wr_pend[p]),
      .wr_addr  (wr_addr[p]),
      .wr_data  (wr_data[p]),
      .rd_pend  (rd_pend[p]),
      .touch    (p_touch[p])
    );
  end

  vport_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_pend    (wr_pend),
    .rd_pend    (rd_pend),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (ptr_q),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .grant_wr   (write_grant),
    .grant_rd   (fetch_grant),
    .rsp_vld    (rsp_route)
  );

  always_comb begin
    cpu_rdata = '0;
    case (cpu_ofs)
      4'h0: cpu_rdata = ptr_q[port_sel][7:0];
      4'h1: cpu_rdata = ptr_q[port_sel][15:8];
      4'h2: cpu_rdata = hi_view(ptr_q[port_sel], code_q[port_sel], dec_q[port_sel]);
      4'h3: cpu_rdata = lat_q[0];
      4'h4: cpu_rdata = lat_q[1];
      4'h5: cpu_rdata = {1'b0, ctrl_q};
      4'h9: if (dual) cpu_rdata = ptr_q[alt_sel][7:0];
      4'hA: if (dual) cpu_rdata = ptr_q[alt_sel][15:8];
      4'hB: if (dual) cpu_rdata = hi_view(ptr_q[alt_sel], code_q[alt_sel], dec_q[alt_sel]);
      default: cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/vport_chk.sv
module vport_chk
  import vport_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cpu_sel,
  input logic                         cpu_we,
  input logic [3:0]                   cpu_ofs,
  input logic [BYTE_W-1:0]            cpu_rdata,
  input logic                         mem_req,
  input logic                         mem_gnt,
  input logic                         mem_we,
  input logic                         mem_rvalid,
  input logic [BYTE_W-1:0]            mem_rdata,
  input logic [NPORT-1:0][VA_W-1:0]   ptr_q,
  input logic [NPORT-1:0][3:0]        code_q,
  input logic [NPORT-1:0]             dec_q,
  input logic [NPORT-1:0][BYTE_W-1:0] lat_q,
  input logic [NPORT-1:0]             rsp_route
);
  logic rd_out;
  always_ff @(posedge clk) begin
    if (!rst_n)                              rd_out <= 1'b0;
    else if (mem_req && mem_gnt && !mem_we)  rd_out <= 1'b1;
    else if (mem_rvalid)                     rd_out <= 1'b0;
  end

  // R11
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out |-> !mem_req);

  // R7
  lat0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_route[0] |=> $stable(lat_q[0]));

  // R7
  lat1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_route[1] |=> $stable(lat_q[1]));

  // R5
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_route[0] |=> lat_q[0] == $past(mem_rdata));

  // R4
  win0_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_ofs == 4'h3) |=>
      ptr_q[0] == step_addr($past(ptr_q[0]), $past(code_q[0]), $past(dec_q[0])));

  // R9
  aux_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !cpu_we && cpu_ofs == 4'hC) |-> cpu_rdata == '0);

  // R8
  ctrl_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !cpu_we && cpu_ofs == 4'h5) |-> !cpu_rdata[7]);
endmodule

bind vport_top vport_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_sel    (cpu_sel),
  .cpu_we     (cpu_we),
  .cpu_ofs    (cpu_ofs),
  .cpu_rdata  (cpu_rdata),
  .mem_req    (mem_req),
  .mem_gnt    (mem_gnt),
  .mem_we     (mem_we),
  .mem_rvalid (mem_rvalid),
  .mem_rdata  (mem_rdata),
  .ptr_q      (ptr_q),
  .code_q     (code_q),
  .dec_q      (dec_q),
  .lat_q      (lat_q),
  .rsp_route  (rsp_route)
);

// File: tb/sim_vport_top.sv
module sim_vport_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_sel = 1'b0;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_ofs = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        mem_req;
  logic        mem_gnt;
  logic        mem_we;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vport_top u0 (.*);

  // memory model: computed pattern plus written bytes, two-cycle read latency
  logic [7:0] wmem [int];
  logic [1:0] stall = '0;
  bit         hold_gnt = 1'b0;
  bit         watch = 1'b0;
  bit         seen = 1'b0;
  logic [16:0] first_addr = '0;
  bit         outst = 1'b0;
  int         proto_err = 0;
  logic       rv1 = 1'b0;
  logic [7:0] rd1 = '0;

  function automatic logic [7:0] pat(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] memval(input logic [16:0] a);
    if (wmem.exists(int'(a))) return wmem[int'(a)];
    return pat(a);
  endfunction

  assign mem_gnt = !hold_gnt && (stall != 2'b11);

  always @(posedge clk) begin
    stall      <= stall + 2'd1;
    rv1        <= 1'b0;
    mem_rvalid <= rv1;
    mem_rdata  <= rd1;
    if (mem_rvalid) outst <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (watch && !seen) begin first_addr <= mem_addr; seen <= 1'b1; end
      if (mem_we) wmem[int'(mem_addr)] = mem_wdata;
      else begin
        if (outst) proto_err <= proto_err + 1;
        outst <= 1'b1;
        rv1   <= 1'b1;
        rd1   <= memval(mem_addr);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ofs, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_ofs = ofs; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] ofs, output logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_ofs = ofs;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_sel = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [3:0] ofs, input logic [7:0] exp);
    logic [7:0] d;
    rd(ofs, d);
    chk(tag, 32'(d), 32'(exp));
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int o = 0; o < 13; o++) begin
      if (o == 6 || o == 7 || o == 8) continue;
      rchk("R1 reset read", 4'(o), 8'h00);
    end
  endtask

  task automatic t_addr();
    wr(4'h5, 8'h00);
    wr(4'h0, 8'h45); wr(4'h1, 8'h23); wr(4'h2, 8'h11);
    wr(4'h5, 8'h01);
    wr(4'h0, 8'hBC); wr(4'h1, 8'h0A); wr(4'h2, 8'h20);
    rchk("R2 p1 lo", 4'h0, 8'hBC);
    rchk("R2 p1 mid", 4'h1, 8'h0A);
    rchk("R2 p1 hi", 4'h2, 8'h20);
    wr(4'h5, 8'h00);
    rchk("R2 p0 lo", 4'h0, 8'h45);
    rchk("R2 p0 mid", 4'h1, 8'h23);
    rchk("R2 p0 hi", 4'h2, 8'h11);
    wr(4'h2, 8'h1F);
    rchk("R3 hi unused bits", 4'h2, 8'h19);
    wr(4'h2, 8'h11);
  endtask

  task automatic t_prefetch();
    settle();
    rchk("R5 first prefetch", 4'h3, pat(17'h12345));
    settle();
    rchk("R4 next byte", 4'h3, pat(17'h12346));
    rchk("R4 pointer moved", 4'h0, 8'h47);
  endtask

  task automatic t_wrap();
    wr(4'h2, 8'h28); wr(4'h1, 8'h00); wr(4'h0, 8'h01);
    settle();
    rchk("R4 dec fetch", 4'h3, pat(17'h00001));
    rchk("R4 dec wrap lo", 4'h0, 8'hFF);
    rchk("R4 dec wrap mid", 4'h1, 8'hFF);
    rchk("R3 dec wrap hi", 4'h2, 8'h29);
    wr(4'h2, 8'h11); wr(4'h1, 8'hFF); wr(4'h0, 8'hFF);
    settle();
    rchk("R4 top fetch", 4'h3, pat(17'h1FFFF));
    rchk("R4 inc wrap lo", 4'h0, 8'h00);
    rchk("R4 inc wrap hi", 4'h2, 8'h10);
    wr(4'h2, 8'h40); wr(4'h1, 8'h00); wr(4'h0, 8'h00);
    settle();
    rd(4'h3, cpu_wdata);
    rchk("R3 code 4 step 8", 4'h0, 8'h08);
  endtask

  task automatic t_write();
    wr(4'h2, 8'h10); wr(4'h1, 8'h01); wr(4'h0, 8'h00);
    settle();
    wr(4'h3, 8'hA5);
    settle();
    rchk("R6 pointer after write", 4'h0, 8'h01);
    wr(4'h0, 8'h00);
    settle();
    rchk("R6 byte stored", 4'h3, 8'hA5);
  endtask

  task automatic t_stale();
    wr(4'h5, 8'h00);
    wr(4'h2, 8'h00); wr(4'h1, 8'h02); wr(4'h0, 8'h00);
    wr(4'h5, 8'h01);
    wr(4'h2, 8'h00); wr(4'h1, 8'h02); wr(4'h0, 8'h00);
    wr(4'h5, 8'h00);
    settle();
    wr(4'h4, 8'h5A);
    settle();
    rchk("R7 other latch stale", 4'h3, pat(17'h00200));
    rchk("R7 own latch refreshed", 4'h4, 8'h5A);
    settle();
    rchk("R4 read refetches", 4'h3, 8'h5A);
  endtask

  task automatic t_aux();
    wr(4'h5, 8'h0C);
    rchk("R9 alt lo", 4'h9, 8'h00);
    rchk("R9 alt mid", 4'hA, 8'h02);
    rchk("R9 alt hi", 4'hB, 8'h00);
    rchk("R9 pad zero", 4'hC, 8'h00);
    wr(4'hB, 8'h10); wr(4'hA, 8'h03); wr(4'h9, 8'h00);
    wr(4'h5, 8'h0D);
    rchk("R9 alt wrote p1 lo", 4'h0, 8'h00);
    rchk("R9 alt wrote p1 mid", 4'h1, 8'h03);
    rchk("R9 alt wrote p1 hi", 4'h2, 8'h10);
    rchk("R9 alt shows p0 mid", 4'hA, 8'h02);
    wr(4'hC, 8'hFF);
    rchk("R9 pad ignores write", 4'hC, 8'h00);
    rchk("R9 pad write no p0 effect", 4'hA, 8'h02);
    rchk("R9 pad write no p1 effect", 4'h1, 8'h03);
    rchk("R8 ctrl readback", 4'h5, 8'h0D);
    wr(4'h5, 8'hFF);
    rchk("R8 ctrl bit7 zero", 4'h5, 8'h7F);
    wr(4'h5, 8'h0A);
    rchk("R10 other code reads zero", 4'hA, 8'h00);
    wr(4'hA, 8'h77);
    wr(4'h5, 8'h0C);
    rchk("R10 other code write ignored", 4'hA, 8'h03);
  endtask

  task automatic t_contend();
    wr(4'h5, 8'h0C);
    wr(4'h2, 8'h00); wr(4'h1, 8'h04);
    wr(4'hB, 8'h00); wr(4'hA, 8'h05);
    settle();
    hold_gnt = 1'b1;
    seen = 1'b0;
    watch = 1'b1;
    wr(4'h0, 8'h10);
    wr(4'h9, 8'h20);
    repeat (4) @(negedge clk);
    hold_gnt = 1'b0;
    settle();
    watch = 1'b0;
    chk("R11 pointer 0 first", 32'(first_addr), 32'h00410);
    rchk("R11 latch 0 after contention", 4'h3, pat(17'h00410));
    rchk("R11 latch 1 after contention", 4'h4, pat(17'h00520));
    chk("R11 one read outstanding", 32'(proto_err), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addr();
    t_prefetch();
    t_wrap();
    t_write();
    t_stale();
    t_aux();
    t_contend();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule